// File: doc/BRIEF.md
# Sampling Converter Serial Readout Port

This block is the digital face of a single-channel sampling converter. Its serial port has three wires: an active-low select, a serial clock driven by the reader, and one data line back to the reader. The block moves through three states. It converts, then sleeps with a result held, then presents that result. A parallel 16-bit input stands in for the analog core and is captured when the fixed conversion time ends. A cycle-count timer models that time.

The single data line does two jobs. While no result is being presented and select is low, it shows whether a conversion is still running. While a result is being presented, it carries the word, most significant bit first. Select and serial clock are brought into the system clock domain through two flip-flops each, and their edges are found on the synchronised copies. Ending a read by raising select starts the next conversion. The port works with the serial clock idling low or idling high.

Top module: `adc_readout_slave`

## Requirements
- R1: While reset is held and just after it, the state output reads CONVERT and the data enable is low. The state encoding is 0 = CONVERT, 1 = SLEEP, 2 = OUTPUT.
- R2: A conversion lasts exactly CONV_CYCLES system clock cycles in CONVERT. At its last cycle `result_in` is captured and the block moves to SLEEP.
- R3: Select and serial clock pass through two synchronising flip-flops. `dout_en` is high exactly when the synchronised select is low, two cycles after the pin.
- R4: With select low, the data line is high while in CONVERT and low while in SLEEP.
- R5: A falling select edge in SLEEP enters OUTPUT, and bit 15 of the captured word appears on the data line without any serial clock edge.
- R6: In OUTPUT the word is sent bit 15 down to bit 0. The next bit appears after each falling serial clock edge and is stable across the following rising edge.
- R7: A falling serial clock edge in OUTPUT that comes before the first rising edge of that access does not advance the word. This lets a clock idling high work.
- R8: Raising select in OUTPUT after at least one rising serial clock edge moves the block to CONVERT and restarts the timer from zero.
- R9: Raising select in OUTPUT before any rising serial clock edge returns the block to SLEEP with the captured word intact, so a later access reads it again from bit 15.
- R10: A falling select edge during CONVERT starts no read. If select is still low when the conversion ends, the block stays in SLEEP until select is raised and lowered again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel_n | input | 1 | Active-low select pin |
| ser_clk | input | 1 | Serial clock pin from the reader |
| result_in | input | WORD_BITS | Parallel result from the conversion core |
| dout | output | 1 | Serial data / status line |
| dout_en | output | 1 | Output enable for the data line; low means high impedance |
| state_o | output | 2 | Current state: 0 CONVERT, 1 SLEEP, 2 OUTPUT |

## Verification
The enable check assumes select is held high during reset, so that the synchroniser's reset value matches the pin two cycles back. The bench keeps select high until well after reset ends. All assertions and checks also assume the reader changes select and serial clock slowly compared with the system clock. The bench therefore holds each pin level for four system cycles, which is more than the synchroniser and edge detector need. It also changes `result_in` only while no capture is pending.

// File: rtl/adc_readout_slave.sv
module adc_readout_slave #(
  parameter int WORD_BITS   = 16,
  parameter int CONV_CYCLES = 166000
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 sel_n,
  input  logic                 ser_clk,
  input  logic [WORD_BITS-1:0] result_in,
  output logic                 dout,
  output logic                 dout_en,
  output logic [1:0]           state_o
);
  localparam int TW = $clog2(CONV_CYCLES + 1);

  typedef enum logic [1:0] {ST_CONV = 2'd0, ST_SLEEP = 2'd1, ST_OUT = 2'd2} st_t;

  st_t                  state;
  logic [TW-1:0]        timer;
  logic [WORD_BITS-1:0] shreg;
  logic                 armed;
  logic [1:0]           sel_sy, clk_sy;
  logic                 sel_q, clk_q;

  wire sel_s    = sel_sy[1];
  wire clk_s    = clk_sy[1];
  wire sel_fall = sel_q & ~sel_s;
  wire sel_rise = ~sel_q & sel_s;
  wire clk_rise = ~clk_q & clk_s;
  wire clk_fall = clk_q & ~clk_s;
  wire conv_end = (timer == TW'(CONV_CYCLES - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_sy <= 2'b11;
      clk_sy <= 2'b00;
      sel_q  <= 1'b1;
      clk_q  <= 1'b0;
    end else begin
      sel_sy <= {sel_sy[0], sel_n};
      clk_sy <= {clk_sy[0], ser_clk};
      sel_q  <= sel_s;
      clk_q  <= clk_s;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_CONV;
      timer <= '0;
      shreg <= '0;
      armed <= 1'b0;
    end else begin
      case (state)
        ST_CONV: begin
          if (conv_end) begin
            state <= ST_SLEEP;
            timer <= '0;
            shreg <= result_in;
          end else begin
            timer <= timer + 1'b1;
          end
        end
        ST_SLEEP: begin
          if (sel_fall) begin
            state <= ST_OUT;
            armed <= 1'b0;
          end
        end
        ST_OUT: begin
          if (sel_rise) begin
            state <= armed ? ST_CONV : ST_SLEEP;
            timer <= '0;
          end else begin
            if (clk_rise) armed <= 1'b1;
            if (clk_fall && armed) shreg <= {shreg[WORD_BITS-2:0], 1'b0};
          end
        end
        default: state <= ST_CONV;
      endcase
    end
  end

  assign dout    = (state == ST_CONV) ? 1'b1 :
                   (state == ST_SLEEP) ? 1'b0 : shreg[WORD_BITS-1];
  assign dout_en = ~sel_s;
  assign state_o = state;
endmodule

// File: rtl/adc_readout_checker.sv
module adc_readout_checker #(
  parameter int WORD_BITS = 16
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 sel_n,
  input logic                 ser_clk,
  input logic [WORD_BITS-1:0] result_in,
  input logic                 dout,
  input logic                 dout_en,
  input logic [1:0]           state_o
);
  a_r1_legal_state: assert property (@(posedge clk) disable iff (!rst_n)
    state_o != 2'd3);

  a_r3_enable_follows_select: assert property (@(posedge clk) disable iff (!rst_n)
    dout_en == !$past(sel_n, 2));

  a_r4_busy_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (dout_en && state_o == 2'd0) |-> dout);

  a_r4_done_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (dout_en && state_o == 2'd1) |-> !dout);

  a_r2_conv_exit: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == 2'd0) |=> (state_o == 2'd0 || state_o == 2'd1));

  a_r5_output_from_sleep: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == 2'd2) |=> (state_o == 2'd2 || !dout_en));

  a_r9_sleep_no_conv: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == 2'd1) |=> (state_o != 2'd0));

  a_r10_conv_not_output: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == 2'd0) |=> (state_o != 2'd2));
endmodule

bind adc_readout_slave adc_readout_checker #(.WORD_BITS(WORD_BITS)) u_chk (.*);

// File: tb/test_adc_readout_slave.sv
module test_adc_readout_slave;
  localparam int CLK_PERIOD = 10;
  localparam int C = 40;

  logic clk = 1'b0, rst_n = 1'b0, sel_n = 1'b1, ser_clk = 1'b0;
  logic [15:0] result_in = 16'hA5C3;
  logic dout, dout_en;
  logic [1:0] state_o;

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  bit exp_q[$];
  string tag_q[$];
  event smp;

  always #(CLK_PERIOD/2) clk = ~clk;

  adc_readout_slave #(.WORD_BITS(16), .CONV_CYCLES(C)) i_adc_readout_slave (
    .clk(clk), .rst_n(rst_n), .sel_n(sel_n), .ser_clk(ser_clk),
    .result_in(result_in), .dout(dout), .dout_en(dout_en), .state_o(state_o));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(smp) begin
    while (exp_q.size() > 0) begin
      bit e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      chk(t, {31'd0, dout}, {31'd0, e});
    end
  end

  task automatic push_bit(input bit e, input string tag);
    exp_q.push_back(e);
    tag_q.push_back(tag);
    -> smp;
    #0;
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  task automatic read_word(input bit cpol, input logic [15:0] w);
    sel_n = 1'b0; settle();
    chk("R5 state", {30'd0, state_o}, 32'd2);
    push_bit(w[15], "R5");
    if (cpol) begin
      ser_clk = 1'b0; settle();
      push_bit(w[15], "R7");
    end
    for (int i = 15; i >= 0; i--) begin
      ser_clk = 1'b1; settle();
      push_bit(w[i], "R6");
      ser_clk = 1'b0; settle();
    end
    if (cpol) begin
      ser_clk = 1'b1; settle();
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  endtask

  task automatic count_conv(input string req);
    int n = 0;
    while (state_o != 2'd0) @(negedge clk);
    while (state_o == 2'd0) begin n++; @(negedge clk); end
    chk(req, n, C);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=running expected=done");
    finish_run();
  end

  initial begin
    repeat (5) @(negedge clk);
    chk("R1 state in reset", {30'd0, state_o}, 32'd0);
    chk("R1 enable in reset", {31'd0, dout_en}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 state after reset", {30'd0, state_o}, 32'd0);
    repeat (C + 2) @(negedge clk);
    chk("R2 sleep after conversion", {30'd0, state_o}, 32'd1);
    chk("R3 enable low with select high", {31'd0, dout_en}, 32'd0);

    read_word(1'b0, 16'hA5C3);
    result_in = 16'h3C96;
    sel_n = 1'b1;
    count_conv("R8 restart lasts CONV_CYCLES");
    chk("R2 sleep after restart", {30'd0, state_o}, 32'd1);

    ser_clk = 1'b1; settle();
    read_word(1'b1, 16'h3C96);
    result_in = 16'h8001;
    sel_n = 1'b1; settle();
    chk("R8 convert after read", {30'd0, state_o}, 32'd0);
    chk("R3 enable off after raise", {31'd0, dout_en}, 32'd0);

    sel_n = 1'b0; settle();
    chk("R3 enable on", {31'd0, dout_en}, 32'd1);
    chk("R10 no read in convert", {30'd0, state_o}, 32'd0);
    push_bit(1'b1, "R4 busy");
    while (state_o == 2'd0) @(negedge clk);
    settle();
    chk("R10 stays sleep", {30'd0, state_o}, 32'd1);
    push_bit(1'b0, "R4 done");

    sel_n = 1'b1; settle();
    sel_n = 1'b0; settle();
    chk("R5 enter output", {30'd0, state_o}, 32'd2);
    push_bit(1'b1, "R5 msb");
    ser_clk = 1'b0; settle();
    push_bit(1'b1, "R7 no advance");
    sel_n = 1'b1; settle();
    chk("R9 back to sleep", {30'd0, state_o}, 32'd1);
    ser_clk = 1'b1; settle();
    read_word(1'b1, 16'h8001);
    sel_n = 1'b1; settle();
    chk("R8 convert after full read", {30'd0, state_o}, 32'd0);

    result_in = 16'h0F0F;
    ser_clk = 1'b0;
    while (state_o == 2'd0) @(negedge clk);
    read_word(1'b0, 16'h0F0F);
    sel_n = 1'b1;
    settle();
    finish_run();
  end
endmodule